// File: doc/BRIEF.md
# Framed Serial Master Shifter

This block is the shifting engine of a synchronous serial master. It takes one parallel word at a time from an outgoing queue through a valid/ready handshake, frames it with an active-low frame strobe, and shifts it out most significant bit first. The serial clock is derived from the system clock by an even divider. At the same time it collects the bits returned by the peripheral and pushes each finished word toward an incoming queue. The word length can be set anywhere from 4 to 16 bits. Clock polarity and clock phase select one of four edge arrangements.

When another word is waiting at the moment the current one ends, the frame strobe stays low and the next word's first bit follows the previous word's last bit with no idle gap. When nothing is waiting, the word ends with one trailing half bit period before the frame strobe rises. Before the first bit there is one leading half bit period. Word length and divider are captured per word, so settings changed during a word act from the next word onward.

Top module: `spi_frame_master`

## Requirements
- R1: While `enable` is low, `frameN` is 1 and `sclk` is 0 at once, and `txd` is 0 from the next clock on. An active word is abandoned.
- R2: While enabled and idle (`frameN` high), `sclk` equals `cpol` and `txd` keeps the last bit sent.
- R3: `txReady` is high only when enabled, either while idle or in the final system clock of a word. A word is taken on a clock edge with `txValid` and `txReady` both high. `frameN` is low from the next cycle.
- R4: A word carries the low `L` bits of `txData`, where `L` = `wordLen` clamped to 4..16. Those bits leave most significant first, and bits above `L` are ignored.
- R5: One half bit period lasts `clkDiv/2` system clocks. `clkDiv` must be even and at least 2; values below 2 act as 2. A lone word of `L` bits keeps `frameN` low for `clkDiv*(L+1)` clocks: a leading half, `L` bits and a trailing half.
- R6: Each bit has a first half and a second half. `txd` changes at the start of the first half. `rxd` is sampled at the edge that starts the second half. During bits, `sclk` = `cpol ^ cpha ^ secondHalf`. Outside bits, `sclk` = `cpol`.
- R7: Received bits enter most significant first. At each completed word, if `rxReady` is high, `rxValid` pulses for one clock with `rxData` holding the `L` bits right-aligned and upper bits zero.
- R8: A run of K words of `L` bits that are handed over back to back keeps `frameN` low for `clkDiv*(K*L+1)` clocks, with no idle bits between words.
- R9: `wordLen` and `clkDiv` are captured when a word is taken. A change made during a word applies to the next word.
- R10: If `rxReady` is low when a word completes, that word is dropped with no `rxValid`. `overrun` is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rstN | input | 1 | asynchronous active-low reset |
| enable | input | 1 | block enable; low forces lines to rest |
| wordLen | input | 5 | bits per word, 4..16 |
| clkDiv | input | 8 | system clocks per serial clock period, even |
| cpol | input | 1 | serial clock rest level |
| cpha | input | 1 | serial clock phase select |
| txData | input | 16 | outgoing word, right-aligned |
| txValid | input | 1 | outgoing word available |
| txReady | output | 1 | outgoing word taken this cycle when valid |
| rxd | input | 1 | serial data from peripheral |
| rxReady | input | 1 | incoming queue has room |
| rxData | output | 16 | received word, right-aligned |
| rxValid | output | 1 | one-cycle push of `rxData` |
| overrun | output | 1 | sticky lost-word flag |
| sclk | output | 1 | serial clock |
| frameN | output | 1 | active-low frame strobe |
| txd | output | 1 | serial data to peripheral |

## Verification
The bench builds the block with its default sizes: a 16-bit word ceiling and an 8-bit divider. This lets it exercise both word-length extremes, 4 and 16, and dividers from 2 to 8 in all four clock modes. A behavioural peripheral returns random words and records `txd` at every sampling edge. Frame durations are measured in system clocks. This covers lone words, back-to-back runs, a mid-word length change, disabling in the middle of a frame, and a full incoming queue.

// File: rtl/spifm_pkg.sv
package spifm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_FIRST,
    PH_SECOND,
    PH_TAIL
  } phase_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic clear;
    logic load;
    logic drive;
    logic sample;
    logic push;
  } dpStrobe_t;

endpackage

// File: rtl/spifm_ctrl.sv
module spifm_ctrl
  import spifm_pkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int MIN_BITS = 4,
  parameter int DIV_W    = 8,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [LEN_W-1:0] wordLen,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             txValid,
  output logic             txReady,
  output logic [LEN_W-1:0] lenSel,
  output dpStrobe_t        strobe,
  output logic             sclk,
  output logic             frameN
);

  localparam int HALF_W = DIV_W - 1;

  phase_e             phase;
  logic [HALF_W-1:0]  halfCnt;
  logic [HALF_W-1:0]  halfLen;
  logic [HALF_W-1:0]  halfSel;
  logic [LEN_W-1:0]   bitCnt;
  logic               tick;
  logic               lastBit;
  logic               boundary;
  logic               accept;

  // clamp the requested word length into the supported range
  always_comb begin
    if (wordLen < LEN_W'(MIN_BITS))      lenSel = LEN_W'(MIN_BITS);
    else if (wordLen > LEN_W'(MAX_BITS)) lenSel = LEN_W'(MAX_BITS);
    else                                 lenSel = wordLen;
  end

  // half period in system clocks, never below one
  always_comb begin
    halfSel = clkDiv[DIV_W-1:1];
    if (halfSel == '0) halfSel = HALF_W'(1);
  end

  assign tick     = (halfCnt == halfLen - 1'b1);
  assign lastBit  = (bitCnt == '0);
  assign boundary = (phase == PH_SECOND) && tick && lastBit;
  assign txReady  = enable && ((phase == PH_IDLE) || boundary);
  assign accept   = txReady && txValid;

  always_comb begin
    strobe        = '0;
    strobe.clear  = !enable;
    strobe.load   = accept;
    strobe.drive  = enable && tick &&
                    ((phase == PH_LEAD) ||
                     ((phase == PH_SECOND) && (!lastBit || accept)));
    strobe.sample = enable && tick && (phase == PH_FIRST);
    strobe.push   = enable && boundary;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      halfCnt <= '0;
      halfLen <= HALF_W'(1);
      bitCnt  <= '0;
    end else if (!enable) begin
      phase   <= PH_IDLE;
      halfCnt <= '0;
      bitCnt  <= '0;
    end else begin
      halfCnt <= tick ? '0 : halfCnt + 1'b1;
      unique case (phase)
        PH_IDLE: begin
          halfCnt <= '0;
          if (accept) begin
            phase   <= PH_LEAD;
            halfLen <= halfSel;
            bitCnt  <= lenSel - 1'b1;
          end
        end
        PH_LEAD: if (tick) phase <= PH_FIRST;
        PH_FIRST: if (tick) phase <= PH_SECOND;
        PH_SECOND: begin
          if (tick) begin
            if (!lastBit) begin
              phase  <= PH_FIRST;
              bitCnt <= bitCnt - 1'b1;
            end else if (accept) begin
              phase   <= PH_FIRST;
              halfLen <= halfSel;
              bitCnt  <= lenSel - 1'b1;
            end else begin
              phase <= PH_TAIL;
            end
          end
        end
        PH_TAIL: if (tick) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    if (!enable)
      sclk = 1'b0;
    else if ((phase == PH_FIRST) || (phase == PH_SECOND))
      sclk = cpol ^ cpha ^ (phase == PH_SECOND);
    else
      sclk = cpol;
  end

  assign frameN = !(enable && (phase != PH_IDLE));

endmodule

// File: rtl/spifm_dp.sv
module spifm_dp
  import spifm_pkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [LEN_W-1:0]    lenSel,
  input  logic [MAX_BITS-1:0] txData,
  input  logic                rxd,
  input  logic                rxReady,
  output logic                txd,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxValid,
  output logic                overrun
);

  logic [MAX_BITS-1:0] txShift;
  logic [MAX_BITS-1:0] rxShift;
  logic [MAX_BITS-1:0] aligned;

  // move the word's top bit to the register's top bit
  assign aligned = txData << (MAX_BITS - int'(lenSel));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      txd     <= 1'b0;
      rxData  <= '0;
      rxValid <= 1'b0;
      overrun <= 1'b0;
    end else if (strobe.clear) begin
      txShift <= '0;
      rxShift <= '0;
      txd     <= 1'b0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strobe.load && strobe.drive) begin
        txd     <= aligned[MAX_BITS-1];
        txShift <= aligned << 1;
      end else if (strobe.load) begin
        txShift <= aligned;
      end else if (strobe.drive) begin
        txd     <= txShift[MAX_BITS-1];
        txShift <= txShift << 1;
      end
      if (strobe.load)
        rxShift <= '0;
      else if (strobe.sample)
        rxShift <= {rxShift[MAX_BITS-2:0], rxd};
      if (strobe.push) begin
        if (rxReady) begin
          rxData  <= rxShift;
          rxValid <= 1'b1;
        end else begin
          overrun <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spifm_pkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int MIN_BITS = 4,
  parameter int DIV_W    = 8,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [LEN_W-1:0]    wordLen,
  input  logic [DIV_W-1:0]    clkDiv,
  input  logic                cpol,
  input  logic                cpha,
  input  logic [MAX_BITS-1:0] txData,
  input  logic                txValid,
  output logic                txReady,
  input  logic                rxd,
  input  logic                rxReady,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxValid,
  output logic                overrun,
  output logic                sclk,
  output logic                frameN,
  output logic                txd
);

  dpStrobe_t        strobe;
  logic [LEN_W-1:0] lenSel;

  spifm_ctrl #(
    .MAX_BITS(MAX_BITS), .MIN_BITS(MIN_BITS), .DIV_W(DIV_W), .LEN_W(LEN_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .wordLen(wordLen),
    .clkDiv(clkDiv), .cpol(cpol), .cpha(cpha), .txValid(txValid),
    .txReady(txReady), .lenSel(lenSel), .strobe(strobe),
    .sclk(sclk), .frameN(frameN)
  );

  spifm_dp #(
    .MAX_BITS(MAX_BITS), .LEN_W(LEN_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lenSel(lenSel),
    .txData(txData), .rxd(rxd), .rxReady(rxReady), .txd(txd),
    .rxData(rxData), .rxValid(rxValid), .overrun(overrun)
  );

endmodule

// File: rtl/spifm_checker.sv
module spifm_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic cpol,
  input logic txReady,
  input logic rxValid,
  input logic overrun,
  input logic sclk,
  input logic frameN,
  input logic txd
);

  p_rest_lines_r1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (frameN && !sclk));

  p_rest_txd_r1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !txd);

  p_idle_clock_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && frameN) |-> (sclk == cpol));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && frameN && $past(enable) && $past(frameN)) |-> $stable(txd));

  p_ready_enabled_r3: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> enable);

  p_push_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

endmodule

bind spi_frame_master spifm_checker chk_i (
  .clk(clk), .rstN(rstN), .enable(enable), .cpol(cpol),
  .txReady(txReady), .rxValid(rxValid), .overrun(overrun),
  .sclk(sclk), .frameN(frameN), .txd(txd)
);

// File: tb/spi_frame_master_tb.sv
`timescale 1ns/1ps
module spi_frame_master_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [4:0]  wordLen = 5'd8;
  logic [7:0]  clkDiv = 8'd2;
  logic        cpolIn = 1'b0;
  logic        cphaIn = 1'b0;
  logic [15:0] txData = '0;
  logic        txValid = 1'b0;
  logic        txReady;
  logic        rxd = 1'b0;
  logic        rxReady = 1'b1;
  logic [15:0] rxData;
  logic        rxValid;
  logic        overrun;
  logic        sclk;
  logic        frameN;
  logic        txd;

  always #2.5 clk = ~clk;

  spi_frame_master dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .wordLen(wordLen),
    .clkDiv(clkDiv), .cpol(cpolIn), .cpha(cphaIn), .txData(txData),
    .txValid(txValid), .txReady(txReady), .rxd(rxd), .rxReady(rxReady),
    .rxData(rxData), .rxValid(rxValid), .overrun(overrun),
    .sclk(sclk), .frameN(frameN), .txd(txd)
  );

  int errors = 0;
  int checks = 0;
  bit expBits [0:1023];
  bit gotBits [0:1023];
  bit slBits  [0:1023];
  logic [15:0] rxExp [0:63];
  int nExp, nGot, nSl, slIdx, nRxExp, rxIdx;
  bit rxBad;
  int lowCnt = 0;
  int lastLow = 0;
  logic prevFrame = 1'b1;
  logic prevSclk = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lowMask(input int n);
    return 16'((32'd1 << n) - 1);
  endfunction

  // peripheral model and line monitor
  always @(negedge clk) begin
    if (prevFrame && !frameN) rxd = (slIdx < nSl) ? slBits[slIdx] : 1'b0;
    if (!frameN && (sclk != prevSclk) && (sclk == (cpolIn ^ cphaIn ^ 1'b1))) begin
      if (nGot < 1024) gotBits[nGot] = txd;
      nGot++;
      slIdx++;
      rxd = (slIdx < nSl) ? slBits[slIdx] : 1'b0;
    end
    if (rxValid) begin
      if (!(rxIdx < nRxExp && rxData == rxExp[rxIdx])) rxBad = 1'b1;
      rxIdx++;
    end
    if (!frameN) lowCnt++;
    else if (!prevFrame) begin
      lastLow = lowCnt;
      lowCnt = 0;
    end
    prevFrame = frameN;
    prevSclk = sclk;
  end

  task automatic runBurst(input int nWords, input int len, input int div,
                          input bit pol, input bit pha, input int newLen,
                          input bit rdy);
    logic [15:0] words [0:7];
    int sumLen;
    bit bitsOk;
    @(negedge clk);
    wordLen = 5'(len); clkDiv = 8'(div); cpolIn = pol; cphaIn = pha; rxReady = rdy;
    nExp = 0; nGot = 0; nSl = 0; slIdx = 0; nRxExp = 0; rxIdx = 0; rxBad = 0; sumLen = 0;
    for (int w = 0; w < nWords; w++) begin
      int l;
      logic [15:0] sw;
      l = (w == 0 || newLen == 0) ? len : newLen;
      words[w] = 16'($urandom);
      sw = 16'($urandom);
      for (int b = l - 1; b >= 0; b--) begin
        expBits[nExp] = words[w][b]; nExp++;
        slBits[nSl] = sw[b]; nSl++;
      end
      if (rdy) begin rxExp[nRxExp] = sw & lowMask(l); nRxExp++; end
      sumLen += l;
    end
    for (int w = 0; w < nWords; w++) begin
      @(negedge clk);
      txData = words[w]; txValid = 1'b1;
      #1;
      while (!txReady) begin @(negedge clk); #1; end
      @(posedge clk);
      if (w == 0) begin
        @(negedge clk); #1;
        check(!frameN, "R3 frame low after take", int'(frameN), 0);
        if (newLen != 0) wordLen = 5'(newLen);  // R9: applies from next word
      end
    end
    @(negedge clk);
    txValid = 1'b0;
    while (!frameN) @(negedge clk);
    @(negedge clk); #1;
    if (nWords > 1)
      check(lastLow == div * (sumLen + 1), "R8 run frame length", lastLow, div * (sumLen + 1));
    else
      check(lastLow == div * (sumLen + 1), "R5 lone frame length", lastLow, div * (sumLen + 1));
    bitsOk = (nGot == nExp);
    for (int i = 0; i < nExp && i < nGot; i++) if (gotBits[i] != expBits[i]) bitsOk = 0;
    check(bitsOk, "R4 R6 R9 transmit bits", nGot, nExp);
    check(!rxBad && rxIdx == nRxExp, "R7 received words", rxIdx, nRxExp);
    check(txd == expBits[nExp-1], "R2 txd holds last bit", int'(txd), int'(expBits[nExp-1]));
    check(sclk == pol && frameN, "R2 idle clock level", int'(sclk), int'(pol));
  endtask

  initial begin
    void'($urandom(32'h1234abcd));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(frameN && !sclk && !txd, "R1 reset lines", {frameN, sclk, txd}, 3'b100);
    check(!txReady && !rxValid && !overrun, "R3 R10 reset outputs",
          {txReady, rxValid, overrun}, 0);
    enable = 1'b1; cpolIn = 1'b1;
    @(negedge clk); #1;
    check(sclk && frameN, "R2 idle sclk follows polarity", int'(sclk), 1);
    check(txReady, "R3 ready while idle", int'(txReady), 1);

    // directed corners
    runBurst(1, 8, 2, 0, 0, 0, 1);
    runBurst(1, 4, 4, 1, 1, 0, 1);
    runBurst(1, 16, 6, 0, 1, 0, 1);
    runBurst(3, 16, 2, 1, 0, 0, 1);
    runBurst(2, 4, 2, 0, 0, 0, 1);
    runBurst(2, 8, 4, 0, 0, 5, 1);   // R9 mid-word length change
    runBurst(3, 12, 8, 1, 1, 4, 1);

    // random mix
    for (int i = 0; i < 24; i++)
      runBurst(1 + int'($urandom % 4), 4 + int'($urandom % 13), 2 * (1 + int'($urandom % 4)),
               1'($urandom), 1'($urandom), 0, 1);

    // full incoming queue
    runBurst(2, 6, 2, 0, 0, 0, 0);
    check(overrun, "R10 overrun set", int'(overrun), 1);
    runBurst(1, 5, 2, 0, 1, 0, 1);
    check(overrun, "R10 overrun sticky", int'(overrun), 1);

    // disable at rest and in mid-frame
    @(negedge clk); enable = 1'b0;
    @(negedge clk); #1;
    check(frameN && !sclk && !txd, "R1 disabled at rest", {frameN, sclk, txd}, 3'b100);
    enable = 1'b1; cpolIn = 1'b0; cphaIn = 1'b0; wordLen = 5'd16; clkDiv = 8'd8;
    txData = 16'hFFFF; txValid = 1'b1;
    repeat (30) @(negedge clk);
    #1;
    check(!frameN && txd, "R4 mid-frame high bit", {frameN, txd}, 2'b01);
    enable = 1'b0; txValid = 1'b0;
    @(negedge clk); #1;
    check(frameN && !sclk && !txd, "R1 disabled mid-frame", {frameN, sclk, txd}, 3'b100);
    check(!txReady, "R3 no ready while disabled", int'(txReady), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule